// File: doc/BRIEF.md
# Periodic Pulse Train Generator

This block produces a repeating pulse train from a single clock. A wide period counter counts down from a programmable reload value. When it reaches zero it raises a wrap carry for one cycle. In that same cycle it reloads itself from the period input and loads a narrow width counter from the width input. The output stays high for as long as the width counter is non-zero. The result is a pulse of programmable width, once every `period_ld + 1` enabled cycles.

The wrap carry is an ordinary synchronous load enable for the width counter and is never used as a clock. A registered copy of the carry appears on `period_tick` so that each period boundary can be seen. The tick rises in the same cycle as the pulse.

Load values are sampled only at a wrap. The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `pulse_train_gen`

## Requirements
- R1: With `en` held high from reset release, `period_tick` is high in the cycle after the first enabled clock edge. It is then high once every `period_ld + 1` enabled edges, for exactly one cycle each time.
- R2: Both counters reload from `period_ld` and `width_ld` only at a wrap. Values changed between wraps have no effect until the next wrap.
- R3: `pulse_out` is high for exactly `width_ld` consecutive cycles, starting in the same cycle as `period_tick`, when `width_ld` is at most `period_ld + 1`.
- R4: A `width_ld` of 0 keeps `pulse_out` low through every period.
- R5: When `width_ld` exceeds `period_ld + 1`, each wrap restarts the width count from `width_ld` before it runs out, so `pulse_out` stays high continuously.
- R6: While `en` is low, both counters hold, `period_tick` stays low and `pulse_out` keeps its value. Counting resumes from the held count.
- R7: A synchronous reset (`rst` high at a clock edge) drives `pulse_out` and `period_tick` low and clears both counters, so the first enabled edge afterwards is a wrap.
- R8: `pulse_out` rises only in a cycle in which `period_tick` is high. A single wrap starts the width count once, and the pulse is never stretched past `width_ld` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both counters |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes both counters |
| period_ld | input | 28 | Period reload value; period is this value plus one cycle |
| width_ld | input | 8 | Pulse width in cycles, loaded at each wrap |
| pulse_out | output | 1 | High while the width counter is non-zero |
| period_tick | output | 1 | One-cycle marker, registered one edge after each wrap |

## Verification
The hardest case to reach is a load value that changes in the middle of a period. It has to be shown that the change is ignored while the pulse is still running, and that it takes effect exactly at the next wrap. The bench starts a long period and changes both load values while the first pulse is still high. It then checks every cycle up to and past the following wrap, so that the position of the new, shorter period and pulse is confirmed. A pause in the middle of a pulse with `en` low is also driven. This confirms that a frozen width counter holds the output, and that the period resumes from its held count.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int unsigned PTG_PERIOD_W = 28;
  localparam int unsigned PTG_WIDTH_W  = 8;
endpackage

// File: rtl/ptg_period_ctr.sv
module ptg_period_ctr #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap    = en && at_zero;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap)   cnt_q <= reload;
    else if (en)     cnt_q <= cnt_q - 1'b1;
  end

  // R1: a non-zero enabled count steps down by exactly one
  a_r1_step_down: assert property (@(posedge clk) disable iff (rst)
    (en && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: a wrap loads the reload value presented in that cycle
  a_r2_reload_at_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == $past(reload)));

  // R6: disabled counter holds
  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/ptg_width_ctr.sv
module ptg_width_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] width,
  output logic         busy
);
  logic [W-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= width;
    else if (en && busy)    cnt_q <= cnt_q - 1'b1;
  end

  // R8: the count never starts again by itself once it has run out
  a_r8_no_self_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R5: a start restarts the count from the load value, even mid-pulse
  a_r5_restart_value: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(width)));
endmodule

// File: rtl/ptg_tick_reg.sv
module ptg_tick_reg (
  input  logic clk,
  input  logic rst,
  input  logic carry,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= carry;
  end
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int unsigned PERIOD_W = ptg_pkg::PTG_PERIOD_W,
  parameter int unsigned WIDTH_W  = ptg_pkg::PTG_WIDTH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period_ld,
  input  logic [WIDTH_W-1:0]  width_ld,
  output logic                pulse_out,
  output logic                period_tick
);
  logic wrap_c;

  ptg_period_ctr #(.W(PERIOD_W)) u_period (
    .clk(clk), .rst(rst), .en(en), .reload(period_ld), .wrap(wrap_c)
  );

  ptg_width_ctr #(.W(WIDTH_W)) u_width (
    .clk(clk), .rst(rst), .en(en), .start(wrap_c), .width(width_ld),
    .busy(pulse_out)
  );

  ptg_tick_reg u_tick (
    .clk(clk), .rst(rst), .carry(wrap_c), .tick(period_tick)
  );

  // R7: reset clears the outputs on the following cycle
  a_r7_reset_low: assert property (@(posedge clk)
    rst |=> (!pulse_out && !period_tick));

  // R8: the pulse only rises together with a period tick
  a_r8_rise_with_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> period_tick);

  // R1: the tick is never two cycles wide unless the period is one cycle
  a_r1_single_tick: assert property (@(posedge clk) disable iff (rst)
    (period_tick && $past(period_ld) != '0 && $past(en)) |=> !period_tick);

  // R6: no tick while disabled
  a_r6_no_tick_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !period_tick);

  // R4: a zero width load leaves the output low in the tick cycle
  a_r4_zero_width: assert property (@(posedge clk) disable iff (rst)
    (wrap_c && width_ld == '0) |=> !pulse_out);
endmodule

// File: tb/pulse_train_gen_bench.sv
`timescale 1ns/1ps
module pulse_train_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [27:0] period_ld = '0;
  logic [7:0]  width_ld  = '0;
  logic        pulse_out, period_tick;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pulse_train_gen u_pulse_train_gen (
    .clk(clk), .rst(rst), .en(en), .period_ld(period_ld),
    .width_ld(width_ld), .pulse_out(pulse_out), .period_tick(period_tick)
  );

  localparam int NV = 6;
  localparam int VP[NV] = '{4, 0, 9, 3, 7, 20};
  localparam int VW[NV] = '{2, 1, 0, 6, 8, 5};

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp, input int n);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, n, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    edge_step(); edge_step();
    chk("R7 pulse", pulse_out, 1'b0, 0);
    chk("R7 tick", period_tick, 1'b0, 0);
    rst = 1'b0; en = 1'b1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Table walk: R1, R3, R4, R5 by closed form over cycle index
    for (int v = 0; v < NV; v++) begin
      int p1, wt, ph;
      period_ld = 28'(VP[v]); width_ld = 8'(VW[v]);
      do_reset();
      p1 = VP[v] + 1;
      wt = (VW[v] < p1) ? VW[v] : p1;
      for (int n = 1; n <= 3 * p1 + 5; n++) begin
        edge_step();
        ph = (n - 1) % p1;
        chk("R1 tick", period_tick, ph == 0, n);
        chk(VW[v] == 0 ? "R4 width0" : (VW[v] > p1 ? "R5 retrig" : "R3 pulse"),
            pulse_out, ph < wt, n);
      end
    end

    // R2: mid-period load change takes effect only at next wrap
    period_ld = 28'd9; width_ld = 8'd3;
    do_reset();
    for (int n = 1; n <= 25; n++) begin
      edge_step();
      if (n == 3) begin period_ld = 28'd4; width_ld = 8'd1; end
      if (n <= 10) begin
        chk("R2 tick old", period_tick, n == 1, n);
        chk("R2 pulse old", pulse_out, n <= 3, n);
      end else begin
        chk("R2 tick new", period_tick, ((n - 11) % 5) == 0, n);
        chk("R2 pulse new", pulse_out, ((n - 11) % 5) == 0, n);
      end
    end

    // R6: pause mid-pulse holds output, no tick, count resumes
    period_ld = 28'd4; width_ld = 8'd2;
    do_reset();
    edge_step(); edge_step();
    chk("R6 pre", pulse_out, 1'b1, 2);
    en = 1'b0;
    for (int n = 0; n < 5; n++) begin
      edge_step();
      chk("R6 hold pulse", pulse_out, 1'b1, n);
      chk("R6 no tick", period_tick, 1'b0, n);
    end
    en = 1'b1;
    for (int m = 1; m <= 4; m++) begin
      edge_step();
      chk("R6 resume tick", period_tick, m == 4, m);
      chk("R8 pulse", pulse_out, m == 4, m);
    end

    // R7: reset in the middle of a pulse
    rst = 1'b1;
    edge_step();
    chk("R7 mid pulse", pulse_out, 1'b0, 0);
    chk("R7 mid tick", period_tick, 1'b0, 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule